// File: doc/BRIEF.md
# Memory-to-FIFO Source DMA with Single Descriptor

This block moves a run of bytes from a word-wide memory read port into a downstream data-in FIFO, one 32-bit word at a time. Software fills in two descriptor registers through a small register port. The first register holds the source byte address. The second holds the byte count and two framing flags. Writing the count word starts the copy. While the copy runs, a busy bit reads 1. It returns to 0 only after the FIFO has accepted the final word.

Completion sets a status bit. That bit drives an interrupt line unless a mask bit blocks it. Software clears the bit by writing a 1 to a clear register. A byte-order control can reverse the bytes inside each outgoing word and can also exchange its two 16-bit halves. A final word that carries fewer than four bytes leaves with a valid-byte count, and its unused lanes are zero.

Register offsets (byte addresses on `reg_addr`):

| Offset | Access | Contents |
| --- | --- | --- |
| 0x00 | read | status, completion at bit 6 |
| 0x04 | read/write | mask, bit 6 |
| 0x08 | write | clear, a 1 in bit 6 clears the status bit |
| 0x0C | read/write | order control |
| 0x10 | read | busy at bit 0 |
| 0x14 | read/write | source byte address |
| 0x18 | read/write | count word, count in bits 29:0, first flag at bit 30, last flag at bit 31 |

Top module: `memdin_dma`

## Requirements
- R1: After reset the following are all 0: status, mask, order control, source address, the busy bit, `irq`, `mem_req_valid` and `fifo_valid`.
- R2: Writing the source address (offset 0x14) starts nothing. Writing a non-zero count word (offset 0x18) starts a copy. Busy (offset 0x10, bit 0) then reads 1 from the cycle after that write until the final word is accepted.
- R3: The memory requests go to consecutive word addresses. They start at the source address with bits 1:0 forced to 0, and there are ceil(count/4) of them. At most one request is outstanding at a time, and no request is made while a word waits for the FIFO.
- R4: In default order (offset 0x0C = 0), each FIFO word equals the memory word read for it. Memory byte k sits in bits 8k+7:8k.
- R5: Every word except the last has `fifo_nbytes` = 4. The last word has `fifo_nbytes` = count − 4·(words − 1), and its byte lanes k ≥ `fifo_nbytes` are zero (lanes are counted before any reordering).
- R6: Order bit 0 = 1 moves byte k to bits 31−8k:24−8k. Order bit 1 = 1 then swaps bits 31:16 with bits 15:0.
- R7: `fifo_first` is high on the first word only if count-word bit 30 was set. `fifo_last` is high on the final word only if bit 31 was set.
- R8: Status bit 6 (offset 0x00) is 1 from the cycle after the final FIFO acceptance. Busy reads 0 in that same cycle.
- R9: A count of 0 sets status bit 6 in the cycle after the write. It issues no memory request, and busy stays 0.
- R10: `irq` is high exactly when status bit 6 is 1 and mask bit 6 (offset 0x04) is 0.
- R11: Writing offset 0x08 with bit 6 = 1 clears status bit 6. Writing it with bit 6 = 0 leaves the status unchanged.
- R12: Writes to the source address, the count word or the order control are ignored while busy. They do not change the readback or the running copy, and they start no second copy.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, the request address holds steady. While `fifo_valid` is high and `fifo_ready` is low, the FIFO data, byte count and flags hold steady.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Completion interrupt after masking |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Word-aligned byte address of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data, byte k in bits 8k+7:8k |
| fifo_valid | output | 1 | FIFO word valid |
| fifo_ready | input | 1 | FIFO accepts the word |
| fifo_data | output | 32 | Ordered and masked data word |
| fifo_nbytes | output | 3 | Number of valid bytes in the word (1 to 4) |
| fifo_first | output | 1 | First word of a copy whose first flag was set |
| fifo_last | output | 1 | Final word of a copy whose last flag was set |

## Verification
The properties assume a particular memory side. It returns exactly one one-cycle `mem_rsp_valid` for each accepted request, and never before that acceptance. They also assume that register writes arrive one per cycle. `fifo_ready` may do anything. The stimulus keeps to these rules with a memory model that answers in the cycle after each handshake and never otherwise. Per-test stall patterns toggle `mem_req_ready` and `fifo_ready` to exercise the hold rules.

// File: rtl/memdin_pkg.sv
package memdin_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 8 * LANES;
  localparam int NB_W   = $clog2(LANES + 1);
  localparam int OFS_W  = $clog2(LANES);

  localparam int OFF_STATUS = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_CLEAR  = 'h08;
  localparam int OFF_ORDER  = 'h0C;
  localparam int OFF_BUSY   = 'h10;
  localparam int OFF_SRC    = 'h14;
  localparam int OFF_LEN    = 'h18;

  localparam int DONE_BIT  = 6;
  localparam int FIRST_BIT = 30;
  localparam int LAST_BIT  = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_PUSH = 2'd3
  } eng_state_t;
endpackage

// File: rtl/memdin_regs.sv
module memdin_regs
  import memdin_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RAW = 5,
  parameter int CW  = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [RAW-1:0]      reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                busy_i,
  input  logic                done_i,
  output logic                start_o,
  output logic [AW-OFS_W-1:0] src_word_o,
  output logic [CW-1:0]       cnt_o,
  output logic                first_o,
  output logic                last_o,
  output logic [1:0]          order_o,
  output logic                mask_o,
  output logic                irq_o
);
  logic          sts_q, sts_d, sts_en;
  logic          msk_q, msk_en;
  logic [1:0]    ord_q;
  logic          ord_en;
  logic [AW-1:0] src_q;
  logic          src_en;
  logic [31:0]   len_q;
  logic          len_en;
  logic          hit_mask, hit_clr, hit_ord, hit_src, hit_len;

  always_comb begin
    hit_mask = reg_we && (reg_addr == RAW'(OFF_MASK));
    hit_clr  = reg_we && (reg_addr == RAW'(OFF_CLEAR));
    hit_ord  = reg_we && (reg_addr == RAW'(OFF_ORDER));
    hit_src  = reg_we && (reg_addr == RAW'(OFF_SRC));
    hit_len  = reg_we && (reg_addr == RAW'(OFF_LEN));

    msk_en = hit_mask;
    ord_en = hit_ord && !busy_i;
    src_en = hit_src && !busy_i;
    len_en = hit_len && !busy_i;

    // completion takes priority over a clear in the same cycle
    sts_en = done_i || (hit_clr && reg_wdata[DONE_BIT]);
    sts_d  = done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      msk_q <= 1'b0;
      ord_q <= 2'b00;
      src_q <= '0;
      len_q <= '0;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (msk_en) msk_q <= reg_wdata[DONE_BIT];
      if (ord_en) ord_q <= reg_wdata[1:0];
      if (src_en) src_q <= reg_wdata[AW-1:0];
      if (len_en) len_q <= reg_wdata;
    end
  end

  always_comb begin
    start_o    = len_en;
    cnt_o      = reg_wdata[CW-1:0];
    first_o    = reg_wdata[FIRST_BIT];
    last_o     = reg_wdata[LAST_BIT];
    src_word_o = src_q[AW-1:OFS_W];
    order_o    = ord_q;
    mask_o     = msk_q;
    irq_o      = sts_q && !msk_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RAW'(OFF_STATUS): reg_rdata[DONE_BIT] = sts_q;
      RAW'(OFF_MASK):   reg_rdata[DONE_BIT] = msk_q;
      RAW'(OFF_ORDER):  reg_rdata[1:0]      = ord_q;
      RAW'(OFF_BUSY):   reg_rdata[0]        = busy_i;
      RAW'(OFF_SRC):    reg_rdata           = 32'(src_q);
      RAW'(OFF_LEN):    reg_rdata           = len_q;
      default:          reg_rdata           = '0;
    endcase
  end
endmodule

// File: rtl/memdin_engine.sv
module memdin_engine
  import memdin_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-OFS_W-1:0] src_word_i,
  input  logic [CW-1:0]       cnt_i,
  input  logic                first_i,
  input  logic                last_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [AW-1:0]       mem_req_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [WORD_W-1:0]   mem_rsp_data_i,
  output logic                beat_valid_o,
  input  logic                beat_ready_i,
  output logic [WORD_W-1:0]   beat_word_o,
  output logic [NB_W-1:0]     beat_nb_o,
  output logic                beat_first_o,
  output logic                beat_last_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int WA_W = AW - OFS_W;

  eng_state_t        st_q, st_d;
  logic [WA_W-1:0]   wa_q, wa_d;
  logic [CW-1:0]     rem_q, rem_d;
  logic              fst_q, fst_d;
  logic              lst_q, lst_d;
  logic              ctl_en;
  logic [WORD_W-1:0] hold_q;
  logic              hold_en;
  logic              final_beat;

  assign final_beat = (rem_q <= CW'(LANES));

  always_comb begin
    st_d    = st_q;
    wa_d    = wa_q;
    rem_d   = rem_q;
    fst_d   = fst_q;
    lst_d   = lst_q;
    ctl_en  = 1'b0;
    done_o  = 1'b0;
    hold_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ctl_en = 1'b1;
          wa_d   = src_word_i;
          rem_d  = cnt_i;
          fst_d  = first_i;
          lst_d  = last_i;
          if (cnt_i == '0) done_o = 1'b1;
          else             st_d   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mem_req_ready_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid_i) begin
          hold_en = 1'b1;
          st_d    = ST_PUSH;
        end
      end
      ST_PUSH: begin
        if (beat_ready_i) begin
          ctl_en = 1'b1;
          fst_d  = 1'b0;
          if (final_beat) begin
            rem_d  = '0;
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            rem_d = rem_q - CW'(LANES);
            wa_d  = wa_q + WA_W'(1);
            st_d  = ST_REQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wa_q   <= '0;
      rem_q  <= '0;
      fst_q  <= 1'b0;
      lst_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (ctl_en) begin
        wa_q  <= wa_d;
        rem_q <= rem_d;
        fst_q <= fst_d;
        lst_q <= lst_d;
      end
      if (hold_en) hold_q <= mem_rsp_data_i;
    end
  end

  always_comb begin
    mem_req_valid_o = (st_q == ST_REQ);
    mem_req_addr_o  = {wa_q, {OFS_W{1'b0}}};
    beat_valid_o    = (st_q == ST_PUSH);
    beat_word_o     = hold_q;
    beat_nb_o       = final_beat ? NB_W'(rem_q) : NB_W'(LANES);
    beat_first_o    = fst_q;
    beat_last_o     = lst_q && final_beat;
    busy_o          = (st_q != ST_IDLE);
  end
endmodule

// File: rtl/memdin_pack.sv
module memdin_pack
  import memdin_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [NB_W-1:0]   nb_i,
  input  logic [1:0]        order_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] kept;
  logic [WORD_W-1:0] swapped;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign kept[8*k +: 8] = (NB_W'(k) < nb_i) ? word_i[8*k +: 8] : 8'h00;
    assign swapped[8*k +: 8] = order_i[0] ? kept[8*(LANES-1-k) +: 8] : kept[8*k +: 8];
  end

  assign word_o = order_i[1] ? {swapped[HALF-1:0], swapped[WORD_W-1:HALF]} : swapped;
endmodule

// File: rtl/memdin_dma.sv
module memdin_dma
  import memdin_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RAW = 5,
  parameter int CW  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [WORD_W-1:0] fifo_data,
  output logic [NB_W-1:0]   fifo_nbytes,
  output logic              fifo_first,
  output logic              fifo_last
);
  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic                busy_w, done_w, start_w;
  logic [AW-OFS_W-1:0] src_word_w;
  logic [CW-1:0]       cnt_w;
  logic                first_w, last_w, mask_w;
  logic [1:0]          order_w;
  logic [WORD_W-1:0]   raw_word_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  memdin_regs #(.AW(AW), .RAW(RAW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy_i    (busy_w),
    .done_i    (done_w),
    .start_o   (start_w),
    .src_word_o(src_word_w),
    .cnt_o     (cnt_w),
    .first_o   (first_w),
    .last_o    (last_w),
    .order_o   (order_w),
    .mask_o    (mask_w),
    .irq_o     (irq)
  );

  memdin_engine #(.AW(AW), .CW(CW)) u_engine (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .start_i        (start_w),
    .src_word_i     (src_word_w),
    .cnt_i          (cnt_w),
    .first_i        (first_w),
    .last_i         (last_w),
    .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o (mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i (mem_rsp_data),
    .beat_valid_o   (fifo_valid),
    .beat_ready_i   (fifo_ready),
    .beat_word_o    (raw_word_w),
    .beat_nb_o      (fifo_nbytes),
    .beat_first_o   (fifo_first),
    .beat_last_o    (fifo_last),
    .busy_o         (busy_w),
    .done_o         (done_w)
  );

  memdin_pack u_pack (
    .word_i (raw_word_w),
    .nb_i   (fifo_nbytes),
    .order_i(order_w),
    .word_o (fifo_data)
  );
endmodule

// File: rtl/memdin_dma_chk.sv
module memdin_dma_chk
  import memdin_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              msk,
  input logic              irq,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [AW-1:0]     mem_req_addr,
  input logic              fifo_valid,
  input logic              fifo_ready,
  input logic [WORD_W-1:0] fifo_data,
  input logic [NB_W-1:0]   fifo_nbytes,
  input logic              fifo_first,
  input logic              fifo_last
);
  // R13
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data) && $stable(fifo_nbytes)
      && $stable(fifo_first) && $stable(fifo_last));

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !fifo_valid);

  // R2
  push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> busy);

  // R5
  nbytes_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> (fifo_nbytes != '0) && (fifo_nbytes <= NB_W'(LANES)));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msk |-> !irq);
endmodule

bind memdin_dma memdin_dma_chk #(.AW(AW)) u_memdin_dma_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy_w),
  .msk          (mask_w),
  .irq          (irq),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .fifo_valid   (fifo_valid),
  .fifo_ready   (fifo_ready),
  .fifo_data    (fifo_data),
  .fifo_nbytes  (fifo_nbytes),
  .fifo_first   (fifo_first),
  .fifo_last    (fifo_last)
);

// File: tb/memdin_dma_bench.sv
module memdin_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int RAW = 5;

  localparam int NV = 6;
  localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h204, 32'h33F, 32'h400, 32'h1000, 32'h2008};
  localparam int          V_CNT  [NV] = '{16, 7, 5, 1, 64, 10};
  localparam logic [1:0]  V_FLG  [NV] = '{2'b11, 2'b01, 2'b10, 2'b00, 2'b11, 2'b11};
  localparam logic [1:0]  V_ORD  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam int          V_BP   [NV] = '{0, 1, 2, 1, 3, 0};

  logic           clk;
  logic           rst_n;
  logic           reg_we;
  logic [RAW-1:0] reg_addr;
  logic [31:0]    reg_wdata;
  logic [31:0]    reg_rdata;
  logic           irq;
  logic           mem_req_valid, mem_req_ready;
  logic [AW-1:0]  mem_req_addr;
  logic           mem_rsp_valid;
  logic [31:0]    mem_rsp_data;
  logic           fifo_valid, fifo_ready;
  logic [31:0]    fifo_data;
  logic [2:0]     fifo_nbytes;
  logic           fifo_first, fifo_last;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  logic [31:0] g_base;
  int          g_cnt;
  logic [1:0]  g_flg;
  logic [1:0]  g_ord;
  int          g_bp;
  int          beat_idx;
  int          req_idx;
  logic        hs_pend;
  logic [31:0] hs_addr;

  memdin_dma #(.AW(AW), .RAW(RAW), .CW(30)) u_memdin_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .fifo_nbytes(fifo_nbytes),
    .fifo_first(fifo_first), .fifo_last(fifo_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, a[15:0] + 16'h0B17};
  endfunction

  function automatic logic [31:0] shape(input logic [31:0] raw, input int nb, input logic [1:0] ord);
    logic [31:0] o;
    o = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < nb) begin
        if (ord[0]) o[8*(3-k) +: 8] = raw[8*k +: 8];
        else        o[8*k +: 8]     = raw[8*k +: 8];
      end
    end
    if (ord[1]) o = {o[15:0], o[31:16]};
    return o;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = RAW'(off);
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int off, output logic [31:0] v);
    reg_addr = RAW'(off);
    #1;
    v = reg_rdata;
  endtask

  // memory and FIFO models, both acting at the falling edge
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    mem_req_ready = 1'b0;
    fifo_ready = 1'b0;
    hs_pend = 1'b0;
    hs_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = hs_pend;
      if (hs_pend) mem_rsp_data = mem_word(hs_addr);
      mem_req_ready = (g_bp == 0) || ((cyc % (g_bp + 1)) == 0);
      hs_pend = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
      if (hs_pend) begin
        // R3 sequential word addresses
        chk(mem_req_addr == g_base + 32'(4 * req_idx), "R3 req addr", mem_req_addr, g_base + 32'(4 * req_idx));
        req_idx++;
      end
      fifo_ready = (g_bp == 0) || ((cyc % (g_bp + 2)) != 0);
      if (fifo_valid && fifo_ready) begin
        int nw, nb;
        logic [31:0] exp;
        nw = (g_cnt + 3) / 4;
        nb = (beat_idx == nw - 1) ? g_cnt - 4 * (nw - 1) : 4;
        exp = shape(mem_word(g_base + 32'(4 * beat_idx)), nb, g_ord);
        chk(beat_idx < nw, "R4 extra word", 32'(beat_idx), 32'(nw));
        chk(fifo_data == exp, (g_ord == 2'd0) ? "R4 data" : "R6 order", fifo_data, exp);
        chk(32'(fifo_nbytes) == 32'(nb), "R5 nbytes", 32'(fifo_nbytes), 32'(nb));
        chk(fifo_first == (g_flg[0] && beat_idx == 0), "R7 first", 32'(fifo_first), 32'(g_flg[0] && beat_idx == 0));
        chk(fifo_last == (g_flg[1] && beat_idx == nw - 1), "R7 last", 32'(fifo_last), 32'(g_flg[1] && beat_idx == nw - 1));
        beat_idx++;
      end
    end
  end

  task automatic start_xfer(input logic [31:0] a, input int n, input logic [1:0] fl, input logic [1:0] ord, input int bp);
    g_base = a & 32'hFFFF_FFFC;
    g_cnt = n;
    g_flg = fl;
    g_ord = ord;
    g_bp = bp;
    beat_idx = 0;
    req_idx = 0;
    wr('h0C, {30'd0, ord});
    wr('h14, a);
    wr('h18, {fl[1], fl[0], 30'(n)});
  endtask

  task automatic finish_xfer();
    logic [31:0] v;
    int nw;
    nw = (g_cnt + 3) / 4;
    v = 32'd1;
    for (int i = 0; i < 3000 && v[0]; i++) begin
      @(negedge clk);
      rd('h10, v);
    end
    chk(v[0] == 1'b0, "R8 busy clear", v, 32'd0);
    chk(beat_idx == nw, "R4 word count", 32'(beat_idx), 32'(nw));
    chk(req_idx == nw, "R3 request count", 32'(req_idx), 32'(nw));
    rd('h00, v);
    chk(v == 32'h40, "R8 status", v, 32'h40);
    chk(irq == 1'b1, "R10 irq", 32'(irq), 32'd1);
    wr('h08, 32'h40);
    rd('h00, v);
    chk(v == 32'h0, "R11 clear", v, 32'h0);
    chk(irq == 1'b0, "R11 irq low", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    clk = 1'b0;
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    g_base = '0; g_cnt = 0; g_flg = '0; g_ord = '0; g_bp = 0;
    beat_idx = 0; req_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd('h00, v); chk(v == 0, "R1 status", v, 0);
    rd('h04, v); chk(v == 0, "R1 mask", v, 0);
    rd('h0C, v); chk(v == 0, "R1 order", v, 0);
    rd('h10, v); chk(v == 0, "R1 busy", v, 0);
    rd('h14, v); chk(v == 0, "R1 src", v, 0);
    chk(irq == 0 && mem_req_valid == 0 && fifo_valid == 0, "R1 outputs",
        {29'd0, irq, mem_req_valid, fifo_valid}, 0);

    // R2 address write alone starts nothing
    wr('h14, 32'h500);
    repeat (3) @(negedge clk);
    rd('h10, v);
    chk(v == 0 && req_idx == 0 && !mem_req_valid, "R2 no start", v, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      start_xfer(V_ADDR[i], V_CNT[i], V_FLG[i], V_ORD[i], V_BP[i]);
      rd('h10, v);
      chk(v == 32'd1, "R2 busy after start", v, 32'd1);
      finish_xfer();
    end

    // R9 zero count, then R10/R11 mask and clear
    g_cnt = 0; g_bp = 0; beat_idx = 0; req_idx = 0;
    wr('h18, 32'hC000_0000);
    rd('h00, v); chk(v == 32'h40, "R9 status", v, 32'h40);
    rd('h10, v); chk(v == 0, "R9 busy", v, 0);
    repeat (3) @(negedge clk);
    chk(req_idx == 0 && beat_idx == 0, "R9 no reads", 32'(req_idx + beat_idx), 0);
    wr('h08, 32'hFFFF_FFBF);
    rd('h00, v); chk(v == 32'h40, "R11 zero bit ignored", v, 32'h40);
    wr('h04, 32'h40);
    rd('h04, v); chk(v == 32'h40, "R10 mask readback", v, 32'h40);
    chk(irq == 0, "R10 masked", 32'(irq), 0);
    wr('h04, 32'h0);
    #1;
    chk(irq == 1, "R10 unmasked", 32'(irq), 1);
    wr('h08, 32'h40);
    rd('h00, v); chk(v == 0, "R11 cleared", v, 0);

    // R12 writes while busy are ignored
    start_xfer(32'h3000, 40, 2'b11, 2'd0, 3);
    repeat (3) @(negedge clk);
    wr('h14, 32'hDEAD_0000);
    wr('h18, 32'hC000_0008);
    wr('h0C, 32'h3);
    rd('h14, v); chk(v == 32'h3000, "R12 src kept", v, 32'h3000);
    rd('h18, v); chk(v == {2'b11, 30'd40}, "R12 len kept", v, {2'b11, 30'd40});
    rd('h0C, v); chk(v == 0, "R12 order kept", v, 0);
    finish_xfer();
    repeat (5) begin
      @(negedge clk);
      rd('h10, v);
      chk(v == 0 && !mem_req_valid, "R12 no restart", {31'd0, mem_req_valid} | v, 0);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule